// File: doc/BRIEF.md
# Embedded CPU Boot Loader Sequencer

This block brings up an on-chip microcontroller whose program memory is loaded through a register bus. After a start pulse, it first polls an identification register until a supported device ID appears. It then parks the CPU in reset with booting and external memory access enabled, and zeroes the program-memory address pointer. It streams the image into an auto-incrementing data port, rewinds the pointer and reads the image back for comparison. It then releases the CPU with its clock running and judges the health word the firmware leaves in a mailbox register.

The image is supplied by the surrounding logic as a byte source indexed by the sequencer: `img_idx_o` selects a byte and `img_byte_i` returns it in the same cycle. The length is taken at the start pulse. The register side is a single-outstanding master: a request is held with fixed fields until the slave acknowledges it, and read data is taken in the acknowledge cycle. The outcome is reported as a done flag, an error flag and a fault code. All three hold until the next accepted start.

Top module: `cpu_boot_loader`

## Requirements
- R1: After reset, done_o, err_o and bus_req_o are 0 and fault_o is 0.
- R2: A start pulse is accepted only while no sequence is running; a start during a sequence neither restarts nor alters the bus transaction stream.
- R3: The sequence begins with reads of the ID register (address 0x00); the device ID is read-data bits 27:12 and only 0x7385, 0x7395 and 0x7396 are accepted; a failing read is retried, and after 256 failing reads the run ends with fault 1 and no further bus access.
- R4: Once an ID is accepted, the control register (address 0x04) is written with 0x08C (bits 7, 3 and 2 set, bit 0 clear), followed by a write of 0 to the memory address register (address 0x08).
- R5: The image is then written as img_len writes to the data port (address 0x0C), byte i zero-extended in write i, in rising index order.
- R6: For a non-empty image, the address register is written with 0 again, and the data port is then read back in index order.
- R7: A readback word above 0xFF ends the run at once with fault 2; no further bus access follows.
- R8: A readback whose low byte differs from the image byte is a mismatch; verification stops right after the fifth mismatch, and any mismatch ends the run with fault 3 without releasing the CPU.
- R9: A clean verify is followed by a write of 0x10B to the control register (bits 8, 3, 1 and 0 set) and one read of the mailbox (address 0x10).
- R10: A mailbox word with upper half 0xFFFF gives fault 4; otherwise a lower half below 0x229 gives fault 5; otherwise the run succeeds with fault 0 and err_o low.
- R11: At the end of a run done_o rises (err_o high exactly when fault_o is non-zero); done_o, err_o and fault_o hold until the next accepted start, which clears them in the following cycle.
- R12: While bus_req_o is high and bus_ack_i low, bus_req_o stays high and bus_we_o, bus_addr_o and bus_wdata_o stay unchanged.
- R13: With img_len 0, the first address write is followed directly by the release write, with no data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| img_len_i | input | 12 | Image length in bytes, sampled at start |
| img_idx_o | output | 12 | Index of the image byte wanted |
| img_byte_i | input | 8 | Image byte at img_idx_o |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | 8 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access complete; read data valid |
| bus_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Run finished |
| err_o | output | 1 | Run finished with a fault |
| fault_o | output | 3 | Fault code: 0 none, 1 no ID, 2 readback range, 3 mismatch, 4 start failure, 5 old version |

## Verification
The bench goes after the counting edges. It checks an ID found on the 256th read against none found in 256, which catches a poll counter that is off by one in either direction. It checks four, five and six mismatches, which exposes a design that stops one mismatch early or late or that releases the CPU despite a bad byte. It checks a readback above 0xFF, which must end the run at once rather than count as a mismatch. It checks a mailbox with both a dead upper half and an old version, where the wrong priority gives the wrong fault. It checks the exact 0x229 boundary, where a wrong comparison would reject a good version. Zero-length and single-byte images catch pointer and last-index slips, and a start pulse in mid-run catches a design that restarts.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ID,
    S_HOLD,
    S_PTR0,
    S_LOAD,
    S_PTR1,
    S_CHECK,
    S_RUN,
    S_MBOX
  } seq_t;

  typedef enum logic [2:0] {
    F_NONE     = 3'd0,
    F_NOID     = 3'd1,
    F_RANGE    = 3'd2,
    F_MISMATCH = 3'd3,
    F_DEAD     = 3'd4,
    F_OLDVER   = 3'd5
  } fault_t;

  localparam int BIT_SRST  = 0;
  localparam int BIT_CLKEN = 1;
  localparam int BIT_EXTAC = 2;
  localparam int BIT_BOOT  = 3;
  localparam int BIT_HOLD  = 7;
  localparam int BIT_DIV   = 8;

  localparam logic [31:0] CTRL_PARK =
    (32'd1 << BIT_HOLD) | (32'd1 << BIT_BOOT) | (32'd1 << BIT_EXTAC);
  localparam logic [31:0] CTRL_GO =
    (32'd1 << BIT_DIV) | (32'd1 << BIT_BOOT) | (32'd1 << BIT_CLKEN) | (32'd1 << BIT_SRST);

endpackage

// File: rtl/boot_counters.sv
module boot_counters #(
  parameter int LEN_W      = 12,
  parameter int POLL_MAX   = 256,
  parameter int MISS_LIMIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 len_load,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 poll_clr,
  input  logic                 poll_inc,
  input  logic                 idx_clr,
  input  logic                 idx_inc,
  input  logic                 miss_clr,
  input  logic                 miss_inc,
  output logic [LEN_W-1:0]     idx_o,
  output logic                 len_zero,
  output logic                 idx_last,
  output logic                 poll_last,
  output logic [$clog2(MISS_LIMIT+2)-1:0] miss_o
);

  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam int MISS_W = $clog2(MISS_LIMIT + 2);

  logic [LEN_W-1:0]  len_q, idx_q, idx_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              poll_en, idx_en, miss_en;

  always_comb begin
    poll_en = poll_clr | poll_inc;
    poll_d  = poll_clr ? '0 : poll_q + POLL_W'(1);
    idx_en  = idx_clr | idx_inc;
    idx_d   = idx_clr ? '0 : idx_q + LEN_W'(1);
    miss_en = miss_clr | miss_inc;
    miss_d  = miss_clr ? '0 : miss_q + MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      idx_q  <= '0;
      poll_q <= '0;
      miss_q <= '0;
    end else begin
      if (len_load) len_q  <= len_i;
      if (idx_en)   idx_q  <= idx_d;
      if (poll_en)  poll_q <= poll_d;
      if (miss_en)  miss_q <= miss_d;
    end
  end

  assign idx_o     = idx_q;
  assign len_zero  = (len_q == '0);
  assign idx_last  = (idx_q == len_q - LEN_W'(1));
  assign poll_last = (poll_q == POLL_W'(POLL_MAX - 1));
  assign miss_o    = miss_q;

  // R3: failed polls never reach the budget without ending the run
  a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < POLL_W'(POLL_MAX));

  // R8: the mismatch tally never passes the limit
  a_r8_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q <= MISS_W'(MISS_LIMIT));

endmodule

// File: rtl/boot_judge.sv
module boot_judge #(
  parameter int                    NUM_IDS = 3,
  parameter logic [NUM_IDS*16-1:0] ID_LIST = {16'h7396, 16'h7395, 16'h7385},
  parameter logic [15:0]           MIN_VER = 16'h0229
) (
  input  logic [31:0] rdata_i,
  input  logic [7:0]  img_byte_i,
  output logic        id_ok,
  output logic        rb_range,
  output logic        rb_miss,
  output logic        mb_dead,
  output logic        ver_low
);

  logic [NUM_IDS-1:0] hit;
  logic [15:0]        dev_id;

  assign dev_id = rdata_i[27:12];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
    assign hit[g] = (dev_id == ID_LIST[g*16 +: 16]);
  end

  assign id_ok    = |hit;
  assign rb_range = |rdata_i[31:8];
  assign rb_miss  = (rdata_i[7:0] != img_byte_i);
  assign mb_dead  = (rdata_i[31:16] == 16'hFFFF);
  assign ver_low  = (rdata_i[15:0] < MIN_VER);

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          MISS_LIMIT = 4,
  parameter logic [AW-1:0] A_ID     = 8'h00,
  parameter logic [AW-1:0] A_CTRL   = 8'h04,
  parameter logic [AW-1:0] A_PTR    = 8'h08,
  parameter logic [AW-1:0] A_DATA   = 8'h0C,
  parameter logic [AW-1:0] A_MBOX   = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          bus_ack_i,
  input  logic [7:0]    img_byte_i,
  input  logic          id_ok,
  input  logic          rb_range,
  input  logic          rb_miss,
  input  logic          mb_dead,
  input  logic          ver_low,
  input  logic          len_zero,
  input  logic          idx_last,
  input  logic          poll_last,
  input  logic [$clog2(MISS_LIMIT+2)-1:0] miss_i,
  output logic          len_load,
  output logic          poll_clr,
  output logic          poll_inc,
  output logic          idx_clr,
  output logic          idx_inc,
  output logic          miss_clr,
  output logic          miss_inc,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic [2:0]    fault_o
);

  localparam int MISS_W = $clog2(MISS_LIMIT + 2);

  seq_t   st_q, st_d;
  fault_t fault_q, fin_code;
  logic   fin, accept;
  logic   done_q, err_q;

  // next state and counter controls
  always_comb begin
    st_d     = st_q;
    fin      = 1'b0;
    fin_code = F_NONE;
    accept   = 1'b0;
    len_load = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    miss_clr = 1'b0;
    miss_inc = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          accept   = 1'b1;
          len_load = 1'b1;
          poll_clr = 1'b1;
          st_d     = S_ID;
        end
      end
      S_ID: begin
        if (bus_ack_i) begin
          if (id_ok) begin
            st_d = S_HOLD;
          end else if (poll_last) begin
            fin      = 1'b1;
            fin_code = F_NOID;
          end else begin
            poll_inc = 1'b1;
          end
        end
      end
      S_HOLD: begin
        if (bus_ack_i) st_d = S_PTR0;
      end
      S_PTR0: begin
        if (bus_ack_i) begin
          idx_clr = 1'b1;
          st_d    = len_zero ? S_RUN : S_LOAD;
        end
      end
      S_LOAD: begin
        if (bus_ack_i) begin
          if (idx_last) begin
            idx_clr = 1'b1;
            st_d    = S_PTR1;
          end else begin
            idx_inc = 1'b1;
          end
        end
      end
      S_PTR1: begin
        if (bus_ack_i) begin
          miss_clr = 1'b1;
          st_d     = S_CHECK;
        end
      end
      S_CHECK: begin
        if (bus_ack_i) begin
          if (rb_range) begin
            fin      = 1'b1;
            fin_code = F_RANGE;
          end else if (rb_miss && (miss_i == MISS_W'(MISS_LIMIT))) begin
            fin      = 1'b1;
            fin_code = F_MISMATCH;
          end else if (idx_last) begin
            if (rb_miss || (miss_i != '0)) begin
              fin      = 1'b1;
              fin_code = F_MISMATCH;
            end else begin
              st_d = S_RUN;
            end
          end else begin
            idx_inc  = 1'b1;
            miss_inc = rb_miss;
          end
        end
      end
      S_RUN: begin
        if (bus_ack_i) st_d = S_MBOX;
      end
      S_MBOX: begin
        if (bus_ack_i) begin
          fin = 1'b1;
          if (mb_dead)      fin_code = F_DEAD;
          else if (ver_low) fin_code = F_OLDVER;
          else              fin_code = F_NONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_IDLE;
  end

  // state and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fault_q <= F_NONE;
    end else begin
      st_q <= st_d;
      if (accept) begin
        done_q  <= 1'b0;
        err_q   <= 1'b0;
        fault_q <= F_NONE;
      end else if (fin) begin
        done_q  <= 1'b1;
        err_q   <= (fin_code != F_NONE);
        fault_q <= fin_code;
      end
    end
  end

  // bus access decode
  always_comb begin
    bus_req_o   = (st_q != S_IDLE);
    bus_we_o    = 1'b0;
    bus_addr_o  = A_ID;
    bus_wdata_o = '0;
    unique case (st_q)
      S_HOLD: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = A_CTRL;
        bus_wdata_o = CTRL_PARK;
      end
      S_PTR0, S_PTR1: begin
        bus_we_o   = 1'b1;
        bus_addr_o = A_PTR;
      end
      S_LOAD: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = A_DATA;
        bus_wdata_o = {24'd0, img_byte_i};
      end
      S_CHECK: bus_addr_o = A_DATA;
      S_RUN: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = A_CTRL;
        bus_wdata_o = CTRL_GO;
      end
      S_MBOX: bus_addr_o = A_MBOX;
      default: ;
    endcase
  end

  assign done_o  = done_q;
  assign err_o   = err_q;
  assign fault_o = fault_q;

  // R12: an unacknowledged request keeps its fields
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                               && $stable(bus_we_o) && $stable(bus_wdata_o));

  // R11: an error is only reported with done
  a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R11: result holds without a start
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(fault_o));

  // R11: accepted start clears result
  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_o && start_i |=> !done_o && !err_o && bus_req_o);

  // R1: no request while a result is shown
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_req_o);

endmodule

// File: rtl/cpu_boot_loader.sv
module cpu_boot_loader #(
  parameter int                    AW         = 8,
  parameter int                    LEN_W      = 12,
  parameter int                    POLL_MAX   = 256,
  parameter int                    MISS_LIMIT = 4,
  parameter int                    NUM_IDS    = 3,
  parameter logic [NUM_IDS*16-1:0] ID_LIST    = {16'h7396, 16'h7395, 16'h7385},
  parameter logic [15:0]           MIN_VER    = 16'h0229,
  parameter logic [AW-1:0]         A_ID       = 8'h00,
  parameter logic [AW-1:0]         A_CTRL     = 8'h04,
  parameter logic [AW-1:0]         A_PTR      = 8'h08,
  parameter logic [AW-1:0]         A_DATA     = 8'h0C,
  parameter logic [AW-1:0]         A_MBOX     = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] img_len_i,
  output logic [LEN_W-1:0] img_idx_o,
  input  logic [7:0]       img_byte_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [31:0]      bus_wdata_o,
  input  logic             bus_ack_i,
  input  logic [31:0]      bus_rdata_i,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       fault_o
);

  localparam int MISS_W = $clog2(MISS_LIMIT + 2);

  logic id_ok, rb_range, rb_miss, mb_dead, ver_low;
  logic len_zero, idx_last, poll_last;
  logic len_load, poll_clr, poll_inc, idx_clr, idx_inc, miss_clr, miss_inc;
  logic [MISS_W-1:0] miss_cnt;

  boot_counters #(
    .LEN_W(LEN_W), .POLL_MAX(POLL_MAX), .MISS_LIMIT(MISS_LIMIT)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .len_load(len_load), .len_i(img_len_i),
    .poll_clr(poll_clr), .poll_inc(poll_inc),
    .idx_clr(idx_clr), .idx_inc(idx_inc),
    .miss_clr(miss_clr), .miss_inc(miss_inc),
    .idx_o(img_idx_o), .len_zero(len_zero), .idx_last(idx_last),
    .poll_last(poll_last), .miss_o(miss_cnt)
  );

  boot_judge #(
    .NUM_IDS(NUM_IDS), .ID_LIST(ID_LIST), .MIN_VER(MIN_VER)
  ) u_judge (
    .rdata_i(bus_rdata_i), .img_byte_i(img_byte_i),
    .id_ok(id_ok), .rb_range(rb_range), .rb_miss(rb_miss),
    .mb_dead(mb_dead), .ver_low(ver_low)
  );

  boot_seq #(
    .AW(AW), .MISS_LIMIT(MISS_LIMIT),
    .A_ID(A_ID), .A_CTRL(A_CTRL), .A_PTR(A_PTR), .A_DATA(A_DATA), .A_MBOX(A_MBOX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_ack_i(bus_ack_i),
    .img_byte_i(img_byte_i),
    .id_ok(id_ok), .rb_range(rb_range), .rb_miss(rb_miss),
    .mb_dead(mb_dead), .ver_low(ver_low),
    .len_zero(len_zero), .idx_last(idx_last), .poll_last(poll_last),
    .miss_i(miss_cnt),
    .len_load(len_load), .poll_clr(poll_clr), .poll_inc(poll_inc),
    .idx_clr(idx_clr), .idx_inc(idx_inc), .miss_clr(miss_clr), .miss_inc(miss_inc),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .done_o(done_o), .err_o(err_o), .fault_o(fault_o)
  );

endmodule

// File: tb/tb_cpu_boot_loader.sv
module tb_cpu_boot_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] img_len = '0;
  logic [11:0] img_idx;
  logic [7:0]  img_byte;
  logic        req, we, ack, done, err;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [2:0]  fault;

  always #10 clk = ~clk;

  cpu_boot_loader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .img_len_i(img_len),
    .img_idx_o(img_idx), .img_byte_i(img_byte),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata),
    .done_o(done), .err_o(err), .fault_o(fault)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  function automatic logic [7:0] img_at(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  assign img_byte = img_at(int'(img_idx));

  // slave configuration
  int          bad_polls;
  logic [15:0] good_id;
  logic [31:0] mbox_val;
  logic [63:0] flip_mask;
  int          big_idx;

  // slave state and log
  logic [7:0]  mem [0:255];
  int          ptr, poll_n, n_log, wait_n, stab_err;
  bit          pend;
  logic [7:0]  cap_addr;
  logic        cap_we;
  logic [31:0] cap_wd;
  logic [7:0]  lg_addr [0:1023];
  logic        lg_we   [0:1023];
  logic [31:0] lg_wd   [0:1023];

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      rdata <= '0;
      pend = 0;
    end else begin
      ack <= 1'b0;
      if (pend && !req) stab_err++;
      if (req && !ack) begin
        if (!pend) begin
          pend = 1; cap_addr = addr; cap_we = we; cap_wd = wdata;
          wait_n = n_log % 3;
        end else if (addr != cap_addr || we != cap_we || wdata != cap_wd) begin
          stab_err++;
        end
        if (wait_n == 0) begin
          pend = 0;
          if (n_log < 1024) begin
            lg_addr[n_log] = addr; lg_we[n_log] = we; lg_wd[n_log] = wdata;
          end
          n_log++;
          ack <= 1'b1;
          if (we) begin
            if (addr == 8'h08) ptr = int'(wdata[7:0]);
            else if (addr == 8'h0C) begin mem[ptr & 255] = wdata[7:0]; ptr++; end
          end else begin
            case (addr)
              8'h00: begin
                poll_n++;
                if (poll_n > bad_polls) rdata <= {4'hF, good_id, 12'hFFF};
                else                   rdata <= {4'hF, 16'h7386, 12'hFFF};
              end
              8'h0C: begin
                if (ptr == big_idx)
                  rdata <= {23'd0, 1'b1, mem[ptr & 255]};
                else if (ptr < 64 && flip_mask[ptr])
                  rdata <= {24'd0, mem[ptr & 255] ^ 8'h5A};
                else
                  rdata <= {24'd0, mem[ptr & 255]};
                ptr++;
              end
              8'h10:   rdata <= mbox_val;
              default: rdata <= 32'hDEAD_BEEF;
            endcase
          end
        end else begin
          wait_n--;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected transaction list
  logic [7:0]  ex_addr [0:1023];
  logic        ex_we   [0:1023];
  logic [31:0] ex_wd   [0:1023];
  int          ne;

  function automatic void push(logic [7:0] a, logic w, logic [31:0] d);
    ex_addr[ne] = a; ex_we[ne] = w; ex_wd[ne] = d; ne++;
  endfunction

  task automatic run(input int len, input int bad, input logic [15:0] id,
                     input logic [31:0] mb, input logic [63:0] flips,
                     input int big, input bit mid_start, input string tag);
    int code, np, miss, bad_ent, wait_c;
    bit stop;
    bad_polls = bad; good_id = id; mbox_val = mb; flip_mask = flips; big_idx = big;
    n_log = 0; poll_n = 0; ptr = 0; stab_err = 0;
    img_len = 12'(len);
    // expected result from the requirements
    ne = 0; code = 0;
    np = (bad >= 256) ? 256 : bad + 1;
    for (int i = 0; i < np; i++) push(8'h00, 1'b0, 32'd0);
    if (bad >= 256) code = 1;
    else begin
      push(8'h04, 1'b1, 32'h08C);
      push(8'h08, 1'b1, 32'd0);
      for (int i = 0; i < len; i++) push(8'h0C, 1'b1, {24'd0, img_at(i)});
      if (len > 0) begin
        push(8'h08, 1'b1, 32'd0);
        miss = 0; stop = 0;
        for (int i = 0; i < len && !stop; i++) begin
          push(8'h0C, 1'b0, 32'd0);
          if (big == i) begin code = 2; stop = 1; end
          else if (i < 64 && flips[i]) begin
            miss++;
            if (miss > 4) begin code = 3; stop = 1; end
          end
        end
        if (!stop && miss > 0) code = 3;
      end
      if (code == 0) begin
        push(8'h04, 1'b1, 32'h10B);
        push(8'h10, 1'b0, 32'd0);
        if (mb[31:16] == 16'hFFFF) code = 4;
        else if (mb[15:0] < 16'h0229) code = 5;
      end
    end
    // launch
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !err, {tag, " R11 start clears result"}, {done, err}, 0);
    if (mid_start) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_c = 0;
    while (!done && wait_c < 5000) begin @(negedge clk); wait_c++; end
    chk(done, {tag, " R11 done"}, done, 1);
    chk(err == (code != 0), {tag, " R10 R11 err flag"}, err, code != 0);
    chk(fault == 3'(code), {tag, " R3 R7 R8 R10 fault"}, fault, code);
    chk(n_log == ne, {tag, " R3 R5 R6 R8 access count"}, n_log, ne);
    bad_ent = 0;
    for (int k = 0; k < ne && k < n_log; k++)
      if (lg_addr[k] != ex_addr[k] || lg_we[k] != ex_we[k] ||
          (ex_we[k] && lg_wd[k] != ex_wd[k])) bad_ent++;
    chk(bad_ent == 0, {tag, " R4 R5 R6 R9 access order"}, bad_ent, 0);
    chk(stab_err == 0, {tag, " R12 request held"}, stab_err, 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!done && !err && !req && fault == 0, "R1 reset state", {done, err, req, fault}, 0);

    // R3: each accepted ID, with and without retries
    run(4, 0, 16'h7385, 32'h0000_0229, 64'd0, -1, 0, "id7385");
    run(4, 3, 16'h7395, 32'h0000_0300, 64'd0, -1, 0, "id7395");
    run(4, 0, 16'h7396, 32'h0001_0229, 64'd0, -1, 0, "id7396");
    // R3 boundaries: found on the 256th read, never found
    run(2, 255, 16'h7385, 32'h0000_0229, 64'd0, -1, 0, "R3 last poll");
    run(2, 1000, 16'h7385, 32'h0000_0229, 64'd0, -1, 0, "R3 timeout");

    // R11 result hold
    repeat (20) @(negedge clk);
    chk(done && err && fault == 3'd1, "R11 hold", {done, err, fault}, 5'b11001);

    // R5 R6 R13 length sweep
    run(0, 0, 16'h7385, 32'h0000_0229, 64'd0, -1, 0, "R13 len0");
    run(1, 0, 16'h7385, 32'h0000_0229, 64'd0, -1, 0, "R5 len1");
    run(5, 1, 16'h7396, 32'h0000_0229, 64'd0, -1, 0, "R5 len5");
    run(17, 0, 16'h7395, 32'h0000_0229, 64'd0, -1, 0, "R6 len17");

    // R8 mismatch sweep: 1..6 mismatches spread over 16 bytes
    for (int k = 1; k <= 6; k++) begin
      logic [63:0] m = '0;
      for (int j = 0; j < k; j++) m[j * 2 + 1] = 1'b1;
      run(16, 0, 16'h7385, 32'h0000_0229, m, -1, 0, $sformatf("R8 miss%0d", k));
    end
    run(8, 0, 16'h7385, 32'h0000_0229, 64'h80, -1, 0, "R8 last byte");

    // R7 out-of-range readback, also after a mismatch
    run(8, 0, 16'h7385, 32'h0000_0229, 64'd0, 3, 0, "R7 range");
    run(8, 0, 16'h7385, 32'h0000_0229, 64'h1, 0, 0, "R7 range first");
    run(8, 0, 16'h7385, 32'h0000_0229, 64'h2, 5, 0, "R7 after miss");

    // R9 R10 mailbox decisions
    run(3, 0, 16'h7385, 32'hFFFF_0300, 64'd0, -1, 0, "R10 dead");
    run(3, 0, 16'h7385, 32'hFFFF_0100, 64'd0, -1, 0, "R10 dead+old");
    run(3, 0, 16'h7385, 32'h0000_0228, 64'd0, -1, 0, "R10 old");
    run(3, 0, 16'h7385, 32'hFFFE_0229, 64'd0, -1, 0, "R9 ok");

    // R2 start during a run is ignored
    run(6, 2, 16'h7395, 32'h0000_0229, 64'd0, -1, 1, "R2 mid start");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule